// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This core keeps a running time value made of a 48-bit seconds count and a 32-bit nanoseconds count. On every clock edge it adds a programmable increment to that value. The increment carries 16 fractional nanosecond bits, and a 16-bit residue register accumulates the fractions, so a clock whose period is not a whole number of nanoseconds still keeps exact time over many cycles.

Two correction mechanisms sit on top of the nominal increment. The first is a slew window. Loading a cycle count together with an alternate period makes the core use that alternate period until the count runs out, which moves the time offset gradually instead of stepping it. The second is a drift trim. A small fractional amount is added as an extra increment once every programmed number of cycles. A parallel load port replaces the time outright.

The surrounding register interface and any software that computes the settings sit outside this block. The block only receives the settings as plain inputs and strobes.

Top module: `tod_counter`

## Requirements
- R1: While the asynchronous active-low reset is applied, seconds, nanoseconds, the remaining slew count and busy all read zero, and the nominal period returns to the parameter NOM_PERIOD (default 20'h50000, which is 5 ns).
- R2: The period is 20 bits wide. Bits 19:16 hold whole nanoseconds and bits 15:0 hold fractions of 2^-16 ns. On each edge the effective period is added to the time. Fractional residue is kept across cycles, and its carry is added into nanoseconds.
- R3: Nanoseconds never reach 1,000,000,000 when counting from an in-range value. A sum at or above that value is reduced by 1,000,000,000 and the 48-bit seconds count is incremented by one.
- R4: A slew load strobe captures a 20-bit count and an alternate period. While the remaining count is nonzero, the alternate period replaces the nominal period, and the count falls by one per edge until it reaches zero.
- R5: A slew count of 1 applies the alternate period on exactly one edge. After that edge the nominal period is used again.
- R6: With a nonzero 16-bit drift rate N, a 16-bit drift amount in 2^-16 ns units is added on top of the period once every N edges. The first addition comes on the N-th edge after the rate becomes nonzero.
- R7: A drift rate of zero disables the drift addition, whatever the drift amount.
- R8: A time load strobe sets seconds and nanoseconds to the load port values on the next edge. It discards that edge's increment and clears the fractional residue. Counting continues from the loaded value on the following edge.
- R9: The busy output is high exactly while the remaining slew count is nonzero.
- R10: A period write strobe updates the nominal period on its edge. That edge still uses the old period, and the new period applies from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | 20 | Nominal period value (4.16 ns) |
| period_wr_i | input | 1 | Write strobe for the nominal period |
| adj_period_i | input | 20 | Alternate period for the slew window (4.16 ns) |
| adj_count_i | input | 20 | Slew window length in cycles |
| adj_load_i | input | 1 | Load strobe for the slew window |
| drift_amt_i | input | 16 | Drift trim per injection, 2^-16 ns units |
| drift_rate_i | input | 16 | Cycles between drift injections, 0 disables |
| time_load_i | input | 1 | Time load strobe |
| load_sec_i | input | 48 | Seconds value to load |
| load_ns_i | input | 32 | Nanoseconds value to load |
| sec_o | output | 48 | Seconds count |
| ns_o | output | 32 | Nanoseconds count |
| adj_remain_o | output | 20 | Remaining slew cycles |
| adj_busy_o | output | 1 | Slew window active |

## Verification
Every strobe takes effect on the first rising edge that samples it. For a time load or a slew load, the loaded value appears on the outputs just after that edge. For a period write, the first edge that uses the new period is the one after the write edge. Drift injections land on edges N, 2N, and so on, counted from the first edge at which the rate is nonzero. The bench drives inputs and samples outputs on falling edges. It counts rising edges exactly from each strobe, so every expected time value is an integer sum of known periods computed in whole and fractional nanoseconds.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  parameter int unsigned PER_W      = 20;
  parameter int unsigned FRAC_W     = 16;
  parameter int unsigned SEC_W      = 48;
  parameter int unsigned NS_W       = 32;
  parameter int unsigned CNT_W      = 20;
  parameter int unsigned DRIFT_W    = 16;
  parameter int unsigned NS_PER_SEC = 1000000000;
  localparam int unsigned INC_W     = PER_W + 1;
endpackage

// File: rtl/tod_adj_ctrl.sv
`timescale 1ns/1ps
module tod_adj_ctrl import tod_pkg::*; #(
  parameter logic [PER_W-1:0] NOM_PERIOD = 20'h50000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  input  logic             period_wr_i,
  input  logic [PER_W-1:0] adj_period_i,
  input  logic [CNT_W-1:0] adj_count_i,
  input  logic             adj_load_i,
  output logic [PER_W-1:0] eff_period_o,
  output logic [CNT_W-1:0] remain_o
);
  logic [PER_W-1:0] nom_q, alt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nom_q <= NOM_PERIOD;
      alt_q <= '0;
      cnt_q <= '0;
    end else begin
      if (period_wr_i) nom_q <= period_i;
      if (adj_load_i) begin
        cnt_q <= adj_count_i;
        alt_q <= adj_period_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign eff_period_o = (cnt_q != '0) ? alt_q : nom_q;
  assign remain_o     = cnt_q;
endmodule

// File: rtl/tod_drift.sv
`timescale 1ns/1ps
module tod_drift import tod_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DRIFT_W-1:0] amt_i,
  input  logic [DRIFT_W-1:0] rate_i,
  output logic [DRIFT_W-1:0] extra_o
);
  logic [DRIFT_W-1:0] dcnt_q;
  logic               en, hit;

  assign en  = (rate_i != '0);
  // >= also covers a rate lowered below the running count
  assign hit = en && (dcnt_q >= rate_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dcnt_q <= '0;
    else if (!en)     dcnt_q <= '0;
    else if (hit)     dcnt_q <= '0;
    else              dcnt_q <= dcnt_q + 1'b1;
  end

  assign extra_o = hit ? amt_i : '0;
endmodule

// File: rtl/tod_time_acc.sv
`timescale 1ns/1ps
module tod_time_acc import tod_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INC_W-1:0]  incr_i,
  input  logic              load_i,
  input  logic [SEC_W-1:0]  load_sec_i,
  input  logic [NS_W-1:0]   load_ns_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o
);
  localparam int unsigned SUM_W = INC_W + 1;
  localparam logic [NS_W:0] NS_LIM = (NS_W+1)'(NS_PER_SEC);

  logic [FRAC_W-1:0] frac_q;
  logic [NS_W-1:0]   ns_q;
  logic [SEC_W-1:0]  sec_q;
  logic [SUM_W-1:0]  sum;
  logic [NS_W:0]     ns_sum;
  logic              wrap;

  assign sum    = SUM_W'(frac_q) + SUM_W'(incr_i);
  assign ns_sum = {1'b0, ns_q} + (NS_W+1)'(sum[SUM_W-1:FRAC_W]);
  assign wrap   = (ns_sum >= NS_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q <= '0;
      ns_q   <= '0;
      sec_q  <= '0;
    end else if (load_i) begin
      frac_q <= '0;
      ns_q   <= load_ns_i;
      sec_q  <= load_sec_i;
    end else begin
      frac_q <= sum[FRAC_W-1:0];
      if (wrap) begin
        ns_q  <= NS_W'(ns_sum - NS_LIM);
        sec_q <= sec_q + 1'b1;
      end else begin
        ns_q  <= ns_sum[NS_W-1:0];
      end
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;
endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter import tod_pkg::*; #(
  parameter logic [PER_W-1:0] NOM_PERIOD = 20'h50000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PER_W-1:0]   period_i,
  input  logic               period_wr_i,
  input  logic [PER_W-1:0]   adj_period_i,
  input  logic [CNT_W-1:0]   adj_count_i,
  input  logic               adj_load_i,
  input  logic [DRIFT_W-1:0] drift_amt_i,
  input  logic [DRIFT_W-1:0] drift_rate_i,
  input  logic               time_load_i,
  input  logic [SEC_W-1:0]   load_sec_i,
  input  logic [NS_W-1:0]    load_ns_i,
  output logic [SEC_W-1:0]   sec_o,
  output logic [NS_W-1:0]    ns_o,
  output logic [CNT_W-1:0]   adj_remain_o,
  output logic               adj_busy_o
);
  logic [PER_W-1:0]   eff_period;
  logic [DRIFT_W-1:0] drift_extra;
  logic [INC_W-1:0]   incr;

  tod_adj_ctrl #(.NOM_PERIOD(NOM_PERIOD)) u_adj (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_i     (period_i),
    .period_wr_i  (period_wr_i),
    .adj_period_i (adj_period_i),
    .adj_count_i  (adj_count_i),
    .adj_load_i   (adj_load_i),
    .eff_period_o (eff_period),
    .remain_o     (adj_remain_o)
  );

  tod_drift u_drift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .amt_i   (drift_amt_i),
    .rate_i  (drift_rate_i),
    .extra_o (drift_extra)
  );

  assign incr = INC_W'(eff_period) + INC_W'(drift_extra);

  tod_time_acc u_time (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .incr_i     (incr),
    .load_i     (time_load_i),
    .load_sec_i (load_sec_i),
    .load_ns_i  (load_ns_i),
    .sec_o      (sec_o),
    .ns_o       (ns_o)
  );

  assign adj_busy_o = (adj_remain_o != '0);
endmodule

// File: rtl/tod_counter_chk.sv
`timescale 1ns/1ps
module tod_counter_chk import tod_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] adj_count_i,
  input logic             adj_load_i,
  input logic             time_load_i,
  input logic [SEC_W-1:0] load_sec_i,
  input logic [NS_W-1:0]  load_ns_i,
  input logic [SEC_W-1:0] sec_o,
  input logic [NS_W-1:0]  ns_o,
  input logic [CNT_W-1:0] adj_remain_o,
  input logic             adj_busy_o
);
  localparam logic [NS_W-1:0] NS_LIM = NS_W'(NS_PER_SEC);

  AST_NS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!time_load_i && ns_o < NS_LIM) |=> (ns_o < NS_LIM)); // R3
  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !time_load_i |=> (sec_o == $past(sec_o)) || (sec_o == $past(sec_o) + 48'd1)); // R3
  AST_ADJ_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_load_i |=> (adj_remain_o == $past(adj_count_i))); // R4
  AST_ADJ_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adj_load_i && adj_remain_o != '0) |=> (adj_remain_o == $past(adj_remain_o) - 1'b1)); // R4
  AST_ADJ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adj_load_i && adj_remain_o == '0) |=> (adj_remain_o == '0)); // R5
  AST_TIME_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_load_i |=> (sec_o == $past(load_sec_i)) && (ns_o == $past(load_ns_i))); // R8
  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_load_i && adj_count_i != '0) |=> adj_busy_o); // R9
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adj_busy_o) |-> ($past(adj_remain_o) == 20'd1 || $past(adj_load_i))); // R9
endmodule

bind tod_counter tod_counter_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .adj_count_i  (adj_count_i),
  .adj_load_i   (adj_load_i),
  .time_load_i  (time_load_i),
  .load_sec_i   (load_sec_i),
  .load_ns_i    (load_ns_i),
  .sec_o        (sec_o),
  .ns_o         (ns_o),
  .adj_remain_o (adj_remain_o),
  .adj_busy_o   (adj_busy_o)
);

// File: tb/sim_tod_counter.sv
`timescale 1ns/1ps
module sim_tod_counter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] period_i = '0;
  logic        period_wr_i = 1'b0;
  logic [19:0] adj_period_i = '0;
  logic [19:0] adj_count_i = '0;
  logic        adj_load_i = 1'b0;
  logic [15:0] drift_amt_i = '0;
  logic [15:0] drift_rate_i = '0;
  logic        time_load_i = 1'b0;
  logic [47:0] load_sec_i = '0;
  logic [31:0] load_ns_i = '0;
  logic [47:0] sec_o;
  logic [31:0] ns_o;
  logic [19:0] adj_remain_o;
  logic        adj_busy_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  tod_counter u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_period(input logic [19:0] p);
    period_i = p; period_wr_i = 1'b1;
    step(1);
    period_wr_i = 1'b0;
  endtask

  task automatic load_time(input logic [47:0] s, input logic [31:0] n);
    load_sec_i = s; load_ns_i = n; time_load_i = 1'b1;
    step(1);
    time_load_i = 1'b0;
  endtask

  task automatic slew(input logic [19:0] p, input logic [19:0] c);
    adj_period_i = p; adj_count_i = c; adj_load_i = 1'b1;
    step(1);
    adj_load_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 sec", sec_o, 0);
    chk("R1 ns", ns_o, 0);
    chk("R1 remain", adj_remain_o, 0);
    chk("R1 busy", adj_busy_o, 0);
    step(4);
    chk("R1 nominal 5ns", ns_o, 20);
  endtask

  task automatic t_frac;
    set_period(20'h18000);
    load_time(0, 0);
    step(3); chk("R2 1.5ns x3", ns_o, 4);
    step(1); chk("R2 1.5ns x4", ns_o, 6);
    set_period(20'h0C000);
    load_time(0, 0);
    step(4); chk("R2 0.75ns x4", ns_o, 3);
  endtask

  task automatic t_period_wr;
    set_period(20'h50000);
    load_time(0, 0);
    period_i = 20'h20000; period_wr_i = 1'b1;
    step(1);
    period_wr_i = 1'b0;
    chk("R10 old period on write edge", ns_o, 5);
    step(2); chk("R10 new period", ns_o, 9);
  endtask

  task automatic t_rollover;
    set_period(20'h50000);
    load_time(48'h0000_FFFF_FFFF, 999_999_990);
    step(1); chk("R3 ns", ns_o, 999_999_995);
    step(1); chk("R3 wrap ns", ns_o, 0);
    chk("R3 wrap sec", sec_o, 48'h0001_0000_0000);
    step(1); chk("R3 after wrap", ns_o, 5);
  endtask

  task automatic t_slew;
    set_period(20'h50000);
    load_time(0, 0);
    slew(20'h80000, 3);
    chk("R4 load edge nominal", ns_o, 5);
    chk("R4 remain", adj_remain_o, 3);
    chk("R9 busy", adj_busy_o, 1);
    step(1);
    chk("R4 alt period", ns_o, 13);
    chk("R4 decrement", adj_remain_o, 2);
    step(2);
    chk("R4 window end", ns_o, 29);
    chk("R9 idle", adj_busy_o, 0);
    step(1); chk("R4 back to nominal", ns_o, 34);
    slew(20'h00000, 2);
    step(2); chk("R4 zero period holds", ns_o, 39);
    step(1); chk("R4 resume", ns_o, 44);
  endtask

  task automatic t_single;
    slew(20'hF0000, 1);
    chk("R5 load edge", ns_o, 49);
    chk("R9 busy one", adj_busy_o, 1);
    step(1);
    chk("R5 one alt cycle", ns_o, 64);
    chk("R5 busy off", adj_busy_o, 0);
    step(1); chk("R5 nominal again", ns_o, 69);
  endtask

  task automatic t_drift;
    set_period(20'h10000);
    drift_amt_i = 16'h8000; drift_rate_i = 16'd4;
    load_time(0, 0);
    step(3);  chk("R6 before first", ns_o, 3);
    step(4);  chk("R6 two injections", ns_o, 8);
    step(4);  chk("R6 three injections", ns_o, 12);
    drift_rate_i = 16'd0;
  endtask

  task automatic t_drift_off;
    set_period(20'h10000);
    drift_amt_i = 16'hFFFF; drift_rate_i = 16'd0;
    load_time(0, 0);
    step(10); chk("R7 rate zero", ns_o, 10);
    drift_amt_i = 16'h0;
  endtask

  task automatic t_load;
    set_period(20'h18000);
    load_time(0, 0);
    step(1); chk("R8 pre", ns_o, 1);
    load_time(7, 100);
    chk("R8 sec", sec_o, 7);
    chk("R8 ns priority", ns_o, 100);
    step(1); chk("R8 residue cleared", ns_o, 101);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    t_reset;
    t_frac;
    t_period_wr;
    t_rollover;
    t_slew;
    t_single;
    t_drift;
    t_drift_off;
    t_load;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule